// File: doc/BRIEF.md
# Edge-Triggered Delayed Sync Pulse Generator

This block takes an asynchronous trip signal, such as an overcurrent comparator output, and turns its rising edge into a delayed one-cycle sync pulse. A downstream PWM generator can use that pulse to end its current period early.

The trip signal first passes through a two-flop synchronizer. A third flop lets the block detect a low-to-high transition on it. When such an edge arrives while the block is idle, a two-state controller enters its running state and captures the programmed match value. An up-counter then starts from zero. The cycle in which the count equals the captured match value produces the sync pulse, and in the next cycle the controller is idle again. The delay is a one-shot: trip edges that arrive while the block is running have no effect.

With a 100 MHz clock, the default match value of 2500 gives a 25 us delay.

Top module: `trip_delay_sync`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `busy` and `sync_pulse` are both 0.
- R2: When `trip_in` goes from 0 to 1 while idle and is stable before a rising clock edge, `busy` is 0 after the second edge and 1 after the third edge.
- R3: The count starts at 0 on entry and increases by one each running cycle. `sync_pulse` is 1 in exactly one cycle: the one in which the count equals the captured match value M. That is M cycles after the first cycle in which `busy` is 1.
- R4: In the cycle after the `sync_pulse` cycle, `busy` is 0, so a run lasts exactly M+1 cycles.
- R5: A match value of 0 gives `sync_pulse` in the first running cycle and a run of one cycle.
- R6: A trip level that stays at 1 after a run has ended starts no new run.
- R7: Trip rising edges that arrive while `busy` is 1 are ignored: they neither restart nor extend the delay.
- R8: `match_val` is sampled only on entry to the running state. Changes to it during a run do not move the pulse.
- R9: `sync_pulse` is never 1 while `busy` is 0.
- R10: A synchronous `rst` during a run aborts the run without a pulse. The following cycles stay idle until a new trip edge arrives.
- R11: With the default match value of 2500, the pulse comes 2500 cycles after `busy` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| trip_in | input | 1 | Raw asynchronous trip signal |
| match_val | input | CNT_W | Delay length in cycles, captured on entry to the running state |
| sync_pulse | output | 1 | One-cycle delayed sync pulse |
| busy | output | 1 | High while the delay is running |

## Verification
A trip edge reaches the `busy` output at the third rising edge: two edges for the synchronizer and one for the state register. `sync_pulse` follows M edges after that, and `busy` falls one edge after the pulse. The bench drives inputs on falling edges and samples on falling edges. It counts edges from the stimulus and checks `busy` and `sync_pulse` in every cycle of each run. This pins the pulse to a single cycle and rules out an early or late pulse, or a lingering `busy`.

// File: rtl/trip_delay_sync.sv
module trip_delay_sync #(
  parameter int CNT_W     = 16,
  parameter int DEF_MATCH = 2500
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trip_in,
  input  logic [CNT_W-1:0] match_val,
  output logic             sync_pulse,
  output logic             busy
);

  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} state_t;

  logic [2:0]       trip_sh;
  state_t           state;
  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] match_q;
  logic             trip_rise;

  assign trip_rise  = trip_sh[1] & ~trip_sh[2];
  assign busy       = (state == ST_RUN);
  assign sync_pulse = busy && (count_q == match_q);

  always_ff @(posedge clk) begin
    if (rst) trip_sh <= '0;
    else     trip_sh <= {trip_sh[1:0], trip_in};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      count_q <= '0;
      match_q <= CNT_W'(DEF_MATCH);
    end else begin
      case (state)
        ST_IDLE: begin
          count_q <= '0;
          if (trip_rise) begin
            state   <= ST_RUN;
            match_q <= match_val;
          end
        end
        default: begin
          if (count_q == match_q) begin
            state   <= ST_IDLE;
            count_q <= '0;
          end else begin
            count_q <= count_q + 1'b1;
          end
        end
      endcase
    end
  end

endmodule

module trip_delay_sync_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             sync_pulse,
  input logic             busy,
  input logic [CNT_W-1:0] count_q,
  input logic [CNT_W-1:0] match_q
);

  assert_pulse_in_run_R9: assert property (@(posedge clk) disable iff (rst)
    sync_pulse |-> busy);

  assert_idle_after_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    sync_pulse |=> !busy);

  assert_run_holds_R3: assert property (@(posedge clk) disable iff (rst)
    (busy && !sync_pulse) |=> busy);

  assert_count_step_R3: assert property (@(posedge clk) disable iff (rst)
    (busy && !sync_pulse) |=> (count_q == $past(count_q) + 1'b1));

  assert_start_zero_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (count_q == '0));

  assert_match_frozen_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(match_q));

endmodule

bind trip_delay_sync trip_delay_sync_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .sync_pulse(sync_pulse), .busy(busy),
  .count_q(count_q), .match_q(match_q)
);

// File: tb/trip_delay_sync_bench.sv
module trip_delay_sync_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        trip_in = 1'b0;
  logic [15:0] match_val = 16'd2500;
  logic        sync_pulse, busy;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  trip_delay_sync u_trip_delay_sync (
    .clk(clk), .rst(rst), .trip_in(trip_in), .match_val(match_val),
    .sync_pulse(sync_pulse), .busy(busy)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic settle_low();
    trip_in = 1'b0;
    repeat (4) tick();
  endtask

  // mode 0: plain, 1: retrigger during run (R7), 2: change match during run (R8)
  task automatic run_delay(input int m, input int mode, input string req);
    settle_low();
    match_val = 16'(m);
    trip_in = 1'b1;
    repeat (2) tick();
    check({req, " R2 busy after 2 edges"}, busy, 0);
    tick();
    check({req, " R2 busy after 3 edges"}, busy, 1);
    for (int i = 0; i <= m; i++) begin
      check({req, " R3 pulse timing"}, sync_pulse, (i == m) ? 1 : 0);
      check({req, " R3 busy during run"}, busy, 1);
      if (mode == 1 && i == 1) trip_in = 1'b0;
      if (mode == 1 && i == 4) trip_in = 1'b1;
      if (mode == 2 && i == 1) match_val = 16'd3;
      tick();
    end
    check({req, " R4 busy after pulse"}, busy, 0);
    check({req, " R4 pulse single cycle"}, sync_pulse, 0);
  endtask

  task automatic test_reset();
    rst = 1'b1;
    trip_in = 1'b0;
    repeat (3) tick();
    check("R1 busy in reset", busy, 0);
    check("R1 pulse in reset", sync_pulse, 0);
    rst = 1'b0;
    tick();
    check("R1 busy after reset", busy, 0);
    check("R1 pulse after reset", sync_pulse, 0);
  endtask

  task automatic test_held_level();
    run_delay(4, 0, "R6 pre");
    for (int i = 0; i < 12; i++) begin
      check("R6 held level busy", busy, 0);
      check("R6 held level pulse", sync_pulse, 0);
      tick();
    end
  endtask

  task automatic test_reset_abort();
    int pulses = 0;
    settle_low();
    match_val = 16'd20;
    trip_in = 1'b1;
    repeat (3) tick();
    check("R10 run started", busy, 1);
    repeat (4) tick();
    trip_in = 1'b0;
    rst = 1'b1;
    tick();
    check("R10 busy during reset", busy, 0);
    rst = 1'b0;
    for (int i = 0; i < 30; i++) begin
      if (sync_pulse) pulses++;
      check("R10 idle after abort", busy, 0);
      tick();
    end
    check("R10 no pulse after abort", pulses, 0);
  endtask

  initial begin
    @(negedge clk);
    test_reset();
    run_delay(5, 0, "R3 m5");
    run_delay(1, 0, "R3 m1");
    run_delay(0, 0, "R5 m0");
    run_delay(12, 1, "R7 retrig");
    run_delay(9, 2, "R8 match change");
    test_held_level();
    test_reset_abort();
    run_delay(2500, 0, "R11 default");
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (50000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule